// File: doc/BRIEF.md
# First-Level Translation Buffer with Variable-Page and 4 KB Arrays

This block is the small, fast translation buffer that sits in front of one access port (instruction or data) and turns a 41-bit virtual address into a 32-bit real address. The virtual address is a 9-bit context in bits [40:32] followed by a 32-bit effective address. The block holds two arrays that are searched in the same cycle. One is a small fully associative array whose entries cover variable page sizes. The other is a set-associative array of fixed 4 KB pages. Software has no access to either array. Hardware fills them from a second-level buffer and empties them on request, so their contents stay a subset of that second level. The instruction and data ports each get their own instance, and the two instances run independently of each other.

A lookup arrives on a valid/ready channel. The result leaves on a second valid/ready channel. A lookup is accepted only when the block is idle and the result slot is free or is being drained in the same cycle. A result stays stable until the consumer takes it. On a miss, the block raises a refill request carrying the virtual address and holds it stable until the second level accepts it. It then waits for the refill response and takes it on a third valid/ready channel. A response that the second level flags as a miss is passed on as a miss and nothing is installed. If two entries match at once, which is a programming error, the real address is undefined and no error is signalled. A one-cycle pulse on the invalidate-all input clears every valid bit.

Top module: `xlat_l1`

## Requirements
- R1: After reset, lk_ready is 1, and res_valid, rf_req_valid and rf_rsp_ready are 0. No entry is valid.
- R2: When a lookup misses in both arrays, rf_req_valid rises with rf_req_va equal to the lookup address. Both are held stable until rf_req_ready is seen. lk_ready stays 0 from the miss until the result is delivered.
- R3: A lookup that hits raises res_valid on the first clock edge after acceptance. res_hit is 1, res_miss is 0, res_ra = {stored 20-bit real page, lk_va[11:0]}, and no refill is requested. A non-miss refill installs the entry and reports it as a hit with the same address form. Matching compares the whole of lk_va[40:12], including the context bits.
- R4: When a refill response has rf_rsp_miss=1, the result has res_miss=1, res_hit=0 and res_ra=0, and nothing is installed. A repeat of the lookup requests a refill again.
- R5: A refill with rf_rsp_var=1 goes to the variable-page array. Size code s (rf_rsp_size) covers a page of 4 KB·4^s. Matching ignores the low 2s bits of lk_va[40:12]. In the real address, the low 12+2s bits come from the virtual address and the rest from rf_rsp_rpn.
- R6: The variable-page array replaces entries in round-robin order. With 4 entries, the fifth install after reset overwrites the first. Invalidate-all does not move the pointer.
- R7: A refill with rf_rsp_var=0 goes to the 4 KB array, in the set selected by lk_va[15:12]. An invalid way is filled first, taking the lowest index. In a full set, the victim is chosen by a pseudo-LRU tree that every install and lookup hit updates. For example, after ways 0–3 are filled in order and way 0 is then hit, the next install evicts way 2.
- R8: Both arrays are searched in the same cycle, and a hit in either array gives the one-cycle hit result of R3.
- R9: A one-cycle pulse on inv_all clears every valid bit in both arrays. A lookup accepted in the same cycle as the pulse is treated as a miss.
- R10: While res_valid=1 and res_ready=0, the result fields are held and lk_ready is 0.
- R11: rf_rsp_ready is 1 only while a refill response is awaited. A rf_rsp_valid seen at any other time installs nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inv_all | input | 1 | Clear all valid bits |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup can be accepted |
| lk_va | input | 41 | Virtual address to translate |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes result |
| res_hit | output | 1 | Translation found |
| res_miss | output | 1 | No translation in either level |
| res_ra | output | 32 | Real address (0 on miss) |
| rf_req_valid | output | 1 | Refill request valid |
| rf_req_ready | input | 1 | Second level accepts request |
| rf_req_va | output | 41 | Address to refill |
| rf_rsp_valid | input | 1 | Refill response valid |
| rf_rsp_ready | output | 1 | Block awaits a response |
| rf_rsp_miss | input | 1 | Second level has no entry |
| rf_rsp_var | input | 1 | Entry is variable-size |
| rf_rsp_size | input | 3 | Size code s, page = 4 KB·4^s |
| rf_rsp_rpn | input | 20 | Real page number |

## Verification
A lost or stray valid bit, a wrong replacement pointer or a corrupted pseudo-LRU tree does not show up when the state goes wrong. It shows up only when a later lookup to an affected page either requests a refill it should not need or skips one it should make, so the bench replays pages after fills and evictions and watches rf_req_valid. A wrong stored page number or size mask appears in res_ra one cycle after a hit. Handshake faults appear within a cycle as a result or request that changes while it is stalled.

// File: rtl/xl1_pkg.sv
package xl1_pkg;
  parameter int VA_W  = 41;
  parameter int RA_W  = 32;
  parameter int PG_SH = 12;
  parameter int SZ_W  = 3;
  localparam int VPN_W = VA_W - PG_SH;
  localparam int RPN_W = RA_W - PG_SH;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} xl1_state_e;

  // low 2*sz page-number bits are offset bits for a variable page
  function automatic logic [VPN_W-1:0] size_mask(input logic [SZ_W-1:0] sz);
    return (VPN_W'(1) << (2 * sz)) - VPN_W'(1);
  endfunction

  function automatic logic [RPN_W-1:0] pn_merge(input logic [RPN_W-1:0] rpn,
                                                input logic [VPN_W-1:0] vpn,
                                                input logic [SZ_W-1:0]  sz);
    logic [VPN_W-1:0] m;
    logic [RPN_W-1:0] ml;
    m  = size_mask(sz);
    ml = m[RPN_W-1:0];
    return (rpn & ~ml) | (vpn[RPN_W-1:0] & ml);
  endfunction
endpackage

// File: rtl/xl1_var_array.sv
module xl1_var_array
  import xl1_pkg::*;
#(
  parameter int N = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inv_all,
  input  logic [VPN_W-1:0] look_vpn,
  output logic             hit,
  output logic [RPN_W-1:0] pn,
  input  logic             ins_en,
  input  logic [VPN_W-1:0] ins_vpn,
  input  logic [SZ_W-1:0]  ins_size,
  input  logic [RPN_W-1:0] ins_rpn
);
  localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

  logic [VPN_W-1:0] vpn_q [N];
  logic [SZ_W-1:0]  sz_q  [N];
  logic [RPN_W-1:0] rpn_q [N];
  logic [N-1:0]     vld_q;
  logic [PTR_W-1:0] ptr_q;

  always_comb begin
    hit = 1'b0;
    pn  = '0;
    for (int i = 0; i < N; i++) begin
      if (vld_q[i] && (((vpn_q[i] ^ look_vpn) & ~size_mask(sz_q[i])) == '0)) begin
        hit = 1'b1;
        pn  = pn | pn_merge(rpn_q[i], look_vpn, sz_q[i]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else begin
      if (inv_all) vld_q <= '0;
      else if (ins_en) vld_q[ptr_q] <= 1'b1;
      if (ins_en) ptr_q <= (ptr_q == PTR_W'(N - 1)) ? '0 : ptr_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (ins_en) begin
      vpn_q[ptr_q] <= ins_vpn & ~size_mask(ins_size);
      sz_q[ptr_q]  <= ins_size;
      rpn_q[ptr_q] <= ins_rpn;
    end
  end

  // R6
  fill_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en && !inv_all |=> vld_q[$past(ptr_q)]);
  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_en |=> $stable(ptr_q));
  // R9
  var_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> !hit);
endmodule

// File: rtl/xl1_fix_array.sv
module xl1_fix_array
  import xl1_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int WAYS    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inv_all,
  input  logic [VPN_W-1:0] look_vpn,
  input  logic             look_fire,
  output logic             hit,
  output logic [RPN_W-1:0] pn,
  input  logic             ins_en,
  input  logic [VPN_W-1:0] ins_vpn,
  input  logic [RPN_W-1:0] ins_rpn
);
  localparam int SETS  = ENTRIES / WAYS;
  localparam int IDX_W = $clog2(SETS);
  localparam int LVL   = $clog2(WAYS);

  logic [VPN_W-1:0] tag_q  [SETS][WAYS];
  logic [RPN_W-1:0] rpn_q  [SETS][WAYS];
  logic [WAYS-1:0]  vld_q  [SETS];
  logic [WAYS-1:1]  tree_q [SETS];

  logic [IDX_W-1:0] look_set, ins_set;
  logic [WAYS-1:0]  match;
  logic [LVL-1:0]   hit_way, vic_way;
  logic             any_vld;

  assign look_set = look_vpn[IDX_W-1:0];
  assign ins_set  = ins_vpn[IDX_W-1:0];

  // tree nodes are heap-indexed from 1; each bit points toward the victim half
  function automatic logic [WAYS-1:1] touch(input logic [WAYS-1:1] t, input logic [LVL-1:0] w);
    logic [WAYS-1:1] r;
    int node;
    r    = t;
    node = int'(w) + WAYS;
    for (int l = 0; l < LVL; l++) begin
      r[node / 2] = ~node[0];
      node = node / 2;
    end
    return r;
  endfunction

  function automatic logic [LVL-1:0] walk(input logic [WAYS-1:1] t);
    int node;
    node = 1;
    for (int l = 0; l < LVL; l++) node = 2 * node + (t[node] ? 1 : 0);
    return LVL'(node - WAYS);
  endfunction

  always_comb begin
    match   = '0;
    pn      = '0;
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (vld_q[look_set][w] && tag_q[look_set][w] == look_vpn) begin
        match[w] = 1'b1;
        pn       = pn | rpn_q[look_set][w];
        hit_way  = LVL'(w);
      end
    end
  end
  assign hit = |match;

  always_comb begin
    if (&vld_q[ins_set]) vic_way = walk(tree_q[ins_set]);
    else begin
      vic_way = '0;
      for (int w = WAYS - 1; w >= 0; w--)
        if (!vld_q[ins_set][w]) vic_way = LVL'(w);
    end
  end

  always_comb begin
    any_vld = 1'b0;
    for (int s = 0; s < SETS; s++) any_vld = any_vld | (|vld_q[s]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s]  <= '0;
        tree_q[s] <= '0;
      end
    end else begin
      if (inv_all) begin
        for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
      end else if (ins_en) begin
        vld_q[ins_set][vic_way] <= 1'b1;
      end
      if (ins_en) tree_q[ins_set] <= touch(tree_q[ins_set], vic_way);
      if (look_fire && hit) tree_q[look_set] <= touch(tree_q[look_set], hit_way);
    end
  end

  always_ff @(posedge clk) begin
    if (ins_en) begin
      tag_q[ins_set][vic_way] <= ins_vpn;
      rpn_q[ins_set][vic_way] <= ins_rpn;
    end
  end

  // R9
  fix_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> !any_vld);
  // R7
  fix_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en && !inv_all |=> any_vld);
endmodule

// File: rtl/xlat_l1.sv
module xlat_l1
  import xl1_pkg::*;
#(
  parameter int VAR_N       = 4,
  parameter int FIX_ENTRIES = 64,
  parameter int FIX_WAYS    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inv_all,
  input  logic            lk_valid,
  output logic            lk_ready,
  input  logic [VA_W-1:0] lk_va,
  output logic            res_valid,
  input  logic            res_ready,
  output logic            res_hit,
  output logic            res_miss,
  output logic [RA_W-1:0] res_ra,
  output logic            rf_req_valid,
  input  logic            rf_req_ready,
  output logic [VA_W-1:0] rf_req_va,
  input  logic            rf_rsp_valid,
  output logic            rf_rsp_ready,
  input  logic            rf_rsp_miss,
  input  logic            rf_rsp_var,
  input  logic [SZ_W-1:0] rf_rsp_size,
  input  logic [RPN_W-1:0] rf_rsp_rpn
);
  xl1_state_e       st_q;
  logic [VA_W-1:0]  miss_va_q;
  logic [VPN_W-1:0] look_vpn, miss_vpn;
  logic             var_hit, fix_hit, any_hit, lk_fire, install;
  logic [RPN_W-1:0] var_pn, fix_pn, hit_pn, fill_pn;

  assign look_vpn = lk_va[VA_W-1:PG_SH];
  assign miss_vpn = miss_va_q[VA_W-1:PG_SH];

  assign lk_ready     = (st_q == ST_IDLE) && (!res_valid || res_ready);
  assign lk_fire      = lk_valid && lk_ready;
  assign rf_req_valid = (st_q == ST_REQ);
  assign rf_req_va    = miss_va_q;
  assign rf_rsp_ready = (st_q == ST_WAIT);
  assign install      = rf_rsp_ready && rf_rsp_valid && !rf_rsp_miss;

  assign any_hit = (var_hit || fix_hit) && !inv_all;
  assign hit_pn  = (var_hit ? var_pn : '0) | (fix_hit ? fix_pn : '0);
  assign fill_pn = rf_rsp_var ? pn_merge(rf_rsp_rpn, miss_vpn, rf_rsp_size) : rf_rsp_rpn;

  xl1_var_array #(.N(VAR_N)) u_var (
    .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
    .look_vpn(look_vpn), .hit(var_hit), .pn(var_pn),
    .ins_en(install && rf_rsp_var), .ins_vpn(miss_vpn),
    .ins_size(rf_rsp_size), .ins_rpn(rf_rsp_rpn)
  );

  xl1_fix_array #(.ENTRIES(FIX_ENTRIES), .WAYS(FIX_WAYS)) u_fix (
    .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
    .look_vpn(look_vpn), .look_fire(lk_fire && !inv_all),
    .hit(fix_hit), .pn(fix_pn),
    .ins_en(install && !rf_rsp_var), .ins_vpn(miss_vpn), .ins_rpn(rf_rsp_rpn)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      miss_va_q <= '0;
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_miss  <= 1'b0;
      res_ra    <= '0;
    end else begin
      if (res_valid && res_ready) res_valid <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (lk_fire) begin
          if (any_hit) begin
            res_valid <= 1'b1;
            res_hit   <= 1'b1;
            res_miss  <= 1'b0;
            res_ra    <= {hit_pn, lk_va[PG_SH-1:0]};
          end else begin
            st_q      <= ST_REQ;
            miss_va_q <= lk_va;
          end
        end
        ST_REQ: if (rf_req_ready) st_q <= ST_WAIT;
        ST_WAIT: if (rf_rsp_valid) begin
          st_q      <= ST_IDLE;
          res_valid <= 1'b1;
          res_hit   <= !rf_rsp_miss;
          res_miss  <= rf_rsp_miss;
          res_ra    <= rf_rsp_miss ? '0 : {fill_pn, miss_va_q[PG_SH-1:0]};
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_req_valid && !rf_req_ready |=> rf_req_valid && $stable(rf_req_va));
  // R2
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_req_valid |-> !lk_ready);
  // R10
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_ra) && $stable(res_hit));
  // R3
  res_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_hit != res_miss));
  // R11
  rsp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_rsp_ready |-> !lk_ready && !rf_req_valid);
endmodule

// File: tb/xlat_l1_test.sv
module xlat_l1_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, inv_all, lk_valid, lk_ready, res_valid, res_ready, res_hit, res_miss;
  logic rf_req_valid, rf_req_ready, rf_rsp_valid, rf_rsp_ready, rf_rsp_miss, rf_rsp_var;
  logic [40:0] lk_va, rf_req_va;
  logic [31:0] res_ra;
  logic [2:0]  rf_rsp_size;
  logic [19:0] rf_rsp_rpn;

  int n_chk = 0, n_bad = 0, stall_left = 0, req_cycles = 0;
  bit done = 0;

  xlat_l1 uut (
    .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_va(lk_va),
    .res_valid(res_valid), .res_ready(res_ready), .res_hit(res_hit),
    .res_miss(res_miss), .res_ra(res_ra),
    .rf_req_valid(rf_req_valid), .rf_req_ready(rf_req_ready), .rf_req_va(rf_req_va),
    .rf_rsp_valid(rf_rsp_valid), .rf_rsp_ready(rf_rsp_ready), .rf_rsp_miss(rf_rsp_miss),
    .rf_rsp_var(rf_rsp_var), .rf_rsp_size(rf_rsp_size), .rf_rsp_rpn(rf_rsp_rpn)
  );

  typedef struct packed {
    logic [40:0] va;
    logic        l2miss;
    logic        var_pg;
    logic [2:0]  sz;
    logic [19:0] rpn;
    logic        exp_refill;
    logic        exp_hit;
    logic [31:0] exp_ra;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{41'h5_0001_2345, 1'b0, 1'b0, 3'd0, 20'hABCDE, 1'b1, 1'b1, 32'hABCDE345},
    '{41'h5_0001_2345, 1'b0, 1'b0, 3'd0, 20'h00000, 1'b0, 1'b1, 32'hABCDE345},
    '{41'h5_0040_1ABC, 1'b1, 1'b0, 3'd0, 20'h00000, 1'b1, 1'b0, 32'h0},
    '{41'h5_0040_1ABC, 1'b1, 1'b0, 3'd0, 20'h00000, 1'b1, 1'b0, 32'h0},
    '{41'h5_1234_5678, 1'b0, 1'b1, 3'd2, 20'h55550, 1'b1, 1'b1, 32'h55555678},
    '{41'h5_1234_0FFF, 1'b0, 1'b1, 3'd2, 20'h00000, 1'b0, 1'b1, 32'h55550FFF},
    '{41'h5_1235_0000, 1'b1, 1'b1, 3'd2, 20'h00000, 1'b1, 1'b0, 32'h0},
    '{41'h6_0001_2345, 1'b1, 1'b0, 3'd0, 20'h00000, 1'b1, 1'b0, 32'h0}
  };

  function automatic string tag_of(int i);
    case (i)
      0, 7:    return "R3";
      1, 5:    return "R8";
      2, 3:    return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [40:0] va, input logic l2miss, input logic var_pg,
                        input logic [2:0] sz, input logic [19:0] rpn, input bit inv_acc,
                        output bit refill, output bit hit, output bit miss, output logic [31:0] ra);
    int guard;
    bit rsp_out;
    refill = 0; hit = 0; miss = 0; ra = '0; rsp_out = 0; req_cycles = 0;
    @(negedge clk);
    lk_valid = 1'b1;
    lk_va    = va;
    guard = 0;
    while (!lk_ready && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    if (inv_acc) inv_all = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0;
    inv_all  = 1'b0;
    guard = 0;
    forever begin
      if (rsp_out) begin
        rf_rsp_valid = 1'b0;
        rsp_out = 0;
      end
      if (res_valid) begin
        hit = res_hit; miss = res_miss; ra = res_ra;
        break;
      end
      if (rf_req_valid) begin
        refill = 1;
        req_cycles++;
        check("R2 refill address", 64'(rf_req_va), 64'(va));
        check("R2 lookup blocked", 64'(lk_ready), 64'd0);
        if (stall_left > 0) begin
          rf_req_ready = 1'b0;
          stall_left--;
        end else rf_req_ready = 1'b1;
      end else if (rf_rsp_ready) begin
        rf_rsp_valid = 1'b1; rf_rsp_miss = l2miss; rf_rsp_var = var_pg;
        rf_rsp_size = sz; rf_rsp_rpn = rpn;
        rsp_out = 1;
      end
      guard++;
      if (guard > 100) begin
        check("R3 result timeout", 64'd1, 64'd0);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic expect_lk(input string req, input logic [40:0] va, input logic l2miss,
                           input logic var_pg, input logic [2:0] sz, input logic [19:0] rpn,
                           input bit inv_acc, input bit e_ref, input bit e_hit, input logic [31:0] e_ra);
    bit r, h, m;
    logic [31:0] a;
    lookup(va, l2miss, var_pg, sz, rpn, inv_acc, r, h, m, a);
    check({req, " refill"}, 64'(r), 64'(e_ref));
    check({req, " hit"}, 64'(h), 64'(e_hit));
    check({req, " ra"}, 64'(a), 64'(e_ra));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit r, h, m;
    logic [31:0] a, ra_hold;
    rst_n = 0; inv_all = 0; lk_valid = 0; lk_va = '0; res_ready = 1; rf_req_ready = 1;
    rf_rsp_valid = 0; rf_rsp_miss = 0; rf_rsp_var = 0; rf_rsp_size = '0; rf_rsp_rpn = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 lk_ready", 64'(lk_ready), 64'd1);
    check("R1 res_valid", 64'(res_valid), 64'd0);
    check("R1 rf_req_valid", 64'(rf_req_valid), 64'd0);
    check("R1 rf_rsp_ready", 64'(rf_rsp_ready), 64'd0);

    foreach (VECS[i]) begin
      lookup(VECS[i].va, VECS[i].l2miss, VECS[i].var_pg, VECS[i].sz, VECS[i].rpn, 1'b0, r, h, m, a);
      check({tag_of(i), " refill"}, 64'(r), 64'(VECS[i].exp_refill));
      check({tag_of(i), " hit"}, 64'(h), 64'(VECS[i].exp_hit));
      check({tag_of(i), " miss"}, 64'(m), 64'(!VECS[i].exp_hit));
      check({tag_of(i), " ra"}, 64'(a), 64'(VECS[i].exp_ra));
    end

    // R2 request held through three stalled cycles
    stall_left = 3;
    expect_lk("R2 stalled", 41'h5_0077_7000, 1'b1, 1'b0, 3'd0, 20'h0, 1'b0, 1'b1, 1'b0, 32'h0);
    check("R2 request cycles", 64'(req_cycles), 64'd4);

    // R11 response outside the waiting state is ignored
    @(negedge clk);
    rf_rsp_valid = 1; rf_rsp_miss = 0; rf_rsp_var = 0; rf_rsp_rpn = 20'h11111;
    check("R11 rsp_ready idle", 64'(rf_rsp_ready), 64'd0);
    repeat (2) @(negedge clk);
    rf_rsp_valid = 0;
    expect_lk("R11 stray", 41'h5_0099_9000, 1'b1, 1'b0, 3'd0, 20'h0, 1'b0, 1'b1, 1'b0, 32'h0);

    // R10 result back-pressure
    @(negedge clk);
    res_ready = 0; lk_valid = 1; lk_va = 41'h5_0001_2345;
    @(negedge clk);
    lk_valid = 0;
    ra_hold = res_ra;
    check("R10 first result", 64'(res_ra), 64'h0000_0000_ABCD_E345);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R10 held valid", 64'(res_valid), 64'd1);
      check("R10 held ra", 64'(res_ra), 64'(ra_hold));
      check("R10 lk_ready low", 64'(lk_ready), 64'd0);
    end
    res_ready = 1;
    @(negedge clk);
    check("R10 drained", 64'(res_valid), 64'd0);
    check("R10 ready again", 64'(lk_ready), 64'd1);

    // R6 round robin: C sits in slot 0, four more installs wrap onto it
    for (int k = 0; k < 4; k++)
      expect_lk("R6 fill", 41'h5_2000_0000 + 41'(k * 4096), 1'b0, 1'b1, 3'd0,
                20'h00101 + 20'(k), 1'b0, 1'b1, 1'b1, {20'h00101 + 20'(k), 12'h000});
    expect_lk("R6 survivor", 41'h5_2000_0010, 1'b1, 1'b0, 3'd0, 20'h0, 1'b0, 1'b0, 1'b1, 32'h00101010);
    expect_lk("R6 evicted", 41'h5_1234_5678, 1'b1, 1'b0, 3'd0, 20'h0, 1'b0, 1'b1, 1'b0, 32'h0);

    // R7 pseudo-LRU in set 7
    for (int k = 1; k <= 4; k++)
      expect_lk("R7 fill", {9'h05, 16'(k), 4'h7, 12'h000}, 1'b0, 1'b0, 3'd0,
                20'hC0000 + 20'(k), 1'b0, 1'b1, 1'b1, {20'hC0000 + 20'(k), 12'h000});
    expect_lk("R7 touch", {9'h05, 16'd1, 4'h7, 12'h000}, 1'b1, 1'b0, 3'd0, 20'h0, 1'b0,
              1'b0, 1'b1, 32'hC0001000);
    expect_lk("R7 replace", {9'h05, 16'd5, 4'h7, 12'h000}, 1'b0, 1'b0, 3'd0, 20'hC0005, 1'b0,
              1'b1, 1'b1, 32'hC0005000);
    expect_lk("R7 victim gone", {9'h05, 16'd3, 4'h7, 12'h000}, 1'b1, 1'b0, 3'd0, 20'h0, 1'b0,
              1'b1, 1'b0, 32'h0);
    expect_lk("R7 keep way1", {9'h05, 16'd2, 4'h7, 12'h000}, 1'b1, 1'b0, 3'd0, 20'h0, 1'b0,
              1'b0, 1'b1, 32'hC0002000);
    expect_lk("R7 keep way3", {9'h05, 16'd4, 4'h7, 12'h000}, 1'b1, 1'b0, 3'd0, 20'h0, 1'b0,
              1'b0, 1'b1, 32'hC0004000);

    // R9 invalidate-all
    @(negedge clk);
    inv_all = 1;
    @(negedge clk);
    inv_all = 0;
    expect_lk("R9 4K cleared", 41'h5_0001_2345, 1'b0, 1'b0, 3'd0, 20'hABCDE, 1'b0, 1'b1, 1'b1, 32'hABCDE345);
    expect_lk("R9 var cleared", 41'h5_2000_0010, 1'b1, 1'b0, 3'd0, 20'h0, 1'b0, 1'b1, 1'b0, 32'h0);
    expect_lk("R9 same cycle", 41'h5_0001_2345, 1'b1, 1'b0, 3'd0, 20'h0, 1'b1, 1'b1, 1'b0, 32'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule